// File: doc/BRIEF.md
# Bridge Status Register Unit

This block holds four 32-bit software-visible registers that sit between a slave bus port and the downstream side of a bus bridge. It records what the downstream side reports: a pending downstream interrupt, an observed downstream reset, a downstream write failure together with the failing data word and address, and the identity of the peripheral that raised the interrupt. It also drives a level interrupt toward the processor.

Software reads the registers to find the cause of a problem. It writes them to act on it. Every write acts on the register's address alone; the block has no write-data port. A write to the status word clears the interrupt. A write to the data word retries the failed write, and a write to the address word abandons it. A write to the source word starts a soft reset that lasts a fixed number of cycles. Everything runs on one clock. Status arrives on a valid-qualified input, and the retry and abandon commands leave as one-cycle pulses.

Three small state machines do the work:
- **Access machine**: states `ACC_IDLE`, `ACC_RDATA` and `ACC_WACK`.
  - `ACC_IDLE` to `ACC_RDATA` on a read request.
  - `ACC_IDLE` to `ACC_WACK` on a write request.
  - Both `ACC_RDATA` and `ACC_WACK` return to `ACC_IDLE` unconditionally.
- **Soft-reset machine**: states `SRST_IDLE` and `SRST_HOLD`.
  - `SRST_IDLE` to `SRST_HOLD` on a soft-reset command.
  - `SRST_HOLD` back to `SRST_IDLE` when the hold counter reaches zero.
- **Status store**: a register bank updated by events, the clear command and the soft reset.

Top module: `bridge_stat_regs`

## Requirements
- R1: After reset, `bus_ready` is 1. `bus_rvalid`, `bus_rdata`, `cmd_continue`, `cmd_abort`, `soft_rst` and `irq_out` are all 0.
- R2: A read of register select 0 (`bus_addr`=2'b00) returns the status word, laid out as follows:
  - bit 0: downstream interrupt seen;
  - bit 1: downstream reset seen;
  - bit 2: downstream write error;
  - bits 31..3: zero.
- R3: A request is taken only in a cycle where `bus_ready`=1 and `bus_sel`=1. For a read (`bus_wr`=0), the select is latched at that edge. In the following cycle `bus_rvalid`=1 and `bus_rdata` carries the selected register. In every other cycle `bus_rvalid`=0 and `bus_rdata`=0.
- R4: A write to select 0 clears all three status bits at the edge that ends the write-acknowledge cycle. An event presented on that same edge is still recorded.
- R5: A write to select 1 makes `cmd_continue` high for exactly the one cycle after the write edge. A write to select 2 does the same for `cmd_abort`. The two are never high together, and neither fires for writes to other selects.
- R6: Select 1 reads the data word of the last failed write, and select 2 reads its address, which is the pre-offset address given on `ev_waddr`. Both are captured when `ev_valid`=1 and `ev_werr`=1, and are held until the next such event.
- R7: Select 3 reads the interrupt source. It is captured from `ev_src` when `ev_valid`=1 and `ev_irq`=1.
- R8: A write to select 3 raises `soft_rst` for exactly HOLD_CYCLES cycles, starting one cycle after the write-acknowledge cycle. Afterwards all status bits and captured words read 0, and events presented during the hold are dropped.
- R9: `irq_out` is 1 exactly when at least one of the three status bits is set. It rises in the cycle after the event edge.
- R10: After any accepted request, `bus_ready` is 0 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (word offset) |
| bus_ready | output | 1 | Block can take a request this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| ev_valid | input | 1 | Status event qualifier |
| ev_irq | input | 1 | Event: downstream interrupt |
| ev_dsrst | input | 1 | Event: downstream reset seen |
| ev_werr | input | 1 | Event: downstream write failed |
| ev_wdata | input | 32 | Data word of the failed write |
| ev_waddr | input | 32 | Pre-offset address of the failed write |
| ev_src | input | 32 | Interrupt source identity |
| cmd_continue | output | 1 | One-cycle retry command |
| cmd_abort | output | 1 | One-cycle abandon command |
| soft_rst | output | 1 | Soft reset pulse |
| irq_out | output | 1 | Level interrupt to processor |

## Verification
Some properties are checked by assertions on every cycle:
- Read data never appears without an accepted read the cycle before.
- Retry and abandon pulses last one cycle.
- `bus_ready` drops after each accepted request.
- An event wins over a simultaneous clear.
- The store is empty after every soft-reset cycle.
- The soft-reset pulse ends only when its counter runs out.

Other behaviour only the bench's scenarios can show:
- the bit layout of the status word;
- which captured word appears at each select;
- the exact length of the soft-reset pulse;
- that events during the hold are lost;
- that each of the eight event combinations gives the expected status word and interrupt level.

// File: rtl/bridge_stat_pkg.sv
package bridge_stat_pkg;

    typedef enum logic [1:0] {
        REG_STAT  = 2'd0,
        REG_WDATA = 2'd1,
        REG_WADDR = 2'd2,
        REG_SRC   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_RDATA = 2'd1,
        ACC_WACK  = 2'd2
    } acc_state_e;

    typedef enum logic {
        SRST_IDLE = 1'b0,
        SRST_HOLD = 1'b1
    } srst_state_e;

    localparam int NSTAT = 3;
    localparam int BIT_IRQ   = 0;
    localparam int BIT_DSRST = 1;
    localparam int BIT_WERR  = 2;

endpackage

// File: rtl/bridge_stat_access.sv
module bridge_stat_access
    import bridge_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_sel,
    input  logic     bus_wr,
    input  logic [1:0] bus_addr,
    output logic     bus_ready,
    output logic     rd_phase,
    output reg_sel_e rd_sel,
    output logic     do_clear,
    output logic     do_continue,
    output logic     do_abort,
    output logic     do_srst
);

    acc_state_e state_q, state_d;
    reg_sel_e   sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (bus_sel) state_d = bus_wr ? ACC_WACK : ACC_RDATA;
            ACC_RDATA: state_d = ACC_IDLE;
            ACC_WACK:  state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
            sel_q   <= REG_STAT;
        end else begin
            state_q <= state_d;
            if (state_q == ACC_IDLE && bus_sel)
                sel_q <= reg_sel_e'(bus_addr);
        end
    end

    always_comb begin
        bus_ready   = 1'b0;
        rd_phase    = 1'b0;
        do_clear    = 1'b0;
        do_continue = 1'b0;
        do_abort    = 1'b0;
        do_srst     = 1'b0;
        unique case (state_q)
            ACC_IDLE:  bus_ready = 1'b1;
            ACC_RDATA: rd_phase  = 1'b1;
            ACC_WACK: begin
                do_clear    = (sel_q == REG_STAT);
                do_continue = (sel_q == REG_WDATA);
                do_abort    = (sel_q == REG_WADDR);
                do_srst     = (sel_q == REG_SRC);
            end
            default: bus_ready = 1'b0;
        endcase
    end

    assign rd_sel = sel_q;

    p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        rd_phase |-> $past(bus_sel && !bus_wr && bus_ready));

    p_busy_after_request_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready) |=> !bus_ready);

    p_continue_single_r5: assert property (@(posedge clk) disable iff (rst)
        do_continue |=> !do_continue);

    p_abort_single_r5: assert property (@(posedge clk) disable iff (rst)
        do_abort |=> !do_abort);

endmodule

// File: rtl/bridge_stat_softrst.sv
module bridge_stat_softrst
    import bridge_stat_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    srst_state_e    state_q, state_d;
    logic [CW-1:0]  cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRST_IDLE: if (start) state_d = SRST_HOLD;
            SRST_HOLD: if (cnt_q == CW'(0)) state_d = SRST_IDLE;
            default:   state_d = SRST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SRST_IDLE && start)
                cnt_q <= CW'(HOLD_CYCLES - 1);
            else if (state_q == SRST_HOLD && cnt_q != CW'(0))
                cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        active = (state_q == SRST_HOLD);
    end

    p_hold_ends_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (active && !$past(active) && $past(!rst)) |-> (cnt_q == CW'(HOLD_CYCLES - 1)));

    p_hold_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(active)) |-> ($past(cnt_q) == CW'(0)));

endmodule

// File: rtl/bridge_stat_store.sv
module bridge_stat_store
    import bridge_stat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             srst,
    input  logic             ev_valid,
    input  logic [NSTAT-1:0] ev_bits,
    input  logic [DW-1:0]    ev_wdata,
    input  logic [DW-1:0]    ev_waddr,
    input  logic [DW-1:0]    ev_src,
    input  reg_sel_e         rd_sel,
    output logic [NSTAT-1:0] stat_bits,
    output logic [DW-1:0]    rd_word
);

    logic [NSTAT-1:0] bits_q, bits_d;
    logic [DW-1:0]    wdata_q, waddr_q, src_q;

    always_comb begin
        for (int i = 0; i < NSTAT; i++) begin
            bits_d[i] = (bits_q[i] & ~clr) | (ev_valid & ev_bits[i]);
        end
        if (srst) bits_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q  <= '0;
            wdata_q <= '0;
            waddr_q <= '0;
            src_q   <= '0;
        end else begin
            bits_q <= bits_d;
            if (srst) begin
                wdata_q <= '0;
                waddr_q <= '0;
                src_q   <= '0;
            end else if (ev_valid) begin
                if (ev_bits[BIT_WERR]) begin
                    wdata_q <= ev_wdata;
                    waddr_q <= ev_waddr;
                end
                if (ev_bits[BIT_IRQ])
                    src_q <= ev_src;
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            REG_STAT:  rd_word = {{(DW-NSTAT){1'b0}}, bits_q};
            REG_WDATA: rd_word = wdata_q;
            REG_WADDR: rd_word = waddr_q;
            REG_SRC:   rd_word = src_q;
            default:   rd_word = '0;
        endcase
    end

    assign stat_bits = bits_q;

    p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $past(clr && ev_valid && ev_bits[BIT_IRQ] && !srst && !rst) |-> bits_q[BIT_IRQ]);

    p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
        $past(clr && !ev_valid && !srst && !rst) |-> (bits_q == '0));

    p_srst_empties_r8: assert property (@(posedge clk) disable iff (rst)
        $past(srst && !rst) |-> (bits_q == '0 && wdata_q == '0 && waddr_q == '0 && src_q == '0));

endmodule

// File: rtl/bridge_stat_regs.sv
module bridge_stat_regs
    import bridge_stat_pkg::*;
#(
    parameter int DW          = 32,
    parameter int HOLD_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    output logic          bus_ready,
    output logic          bus_rvalid,
    output logic [DW-1:0] bus_rdata,
    input  logic          ev_valid,
    input  logic          ev_irq,
    input  logic          ev_dsrst,
    input  logic          ev_werr,
    input  logic [DW-1:0] ev_wdata,
    input  logic [DW-1:0] ev_waddr,
    input  logic [DW-1:0] ev_src,
    output logic          cmd_continue,
    output logic          cmd_abort,
    output logic          soft_rst,
    output logic          irq_out
);

    reg_sel_e         rd_sel;
    logic             rd_phase, do_clear, do_srst;
    logic [NSTAT-1:0] stat_bits, ev_bits;
    logic [DW-1:0]    rd_word;

    assign ev_bits[BIT_IRQ]   = ev_irq;
    assign ev_bits[BIT_DSRST] = ev_dsrst;
    assign ev_bits[BIT_WERR]  = ev_werr;

    bridge_stat_access u_access (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_ready   (bus_ready),
        .rd_phase    (rd_phase),
        .rd_sel      (rd_sel),
        .do_clear    (do_clear),
        .do_continue (cmd_continue),
        .do_abort    (cmd_abort),
        .do_srst     (do_srst)
    );

    bridge_stat_softrst #(.HOLD_CYCLES(HOLD_CYCLES)) u_softrst (
        .clk    (clk),
        .rst    (rst),
        .start  (do_srst),
        .active (soft_rst)
    );

    bridge_stat_store #(.DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (do_clear),
        .srst      (soft_rst),
        .ev_valid  (ev_valid),
        .ev_bits   (ev_bits),
        .ev_wdata  (ev_wdata),
        .ev_waddr  (ev_waddr),
        .ev_src    (ev_src),
        .rd_sel    (rd_sel),
        .stat_bits (stat_bits),
        .rd_word   (rd_word)
    );

    assign bus_rvalid = rd_phase;
    assign bus_rdata  = rd_phase ? rd_word : '0;
    assign irq_out    = |stat_bits;

    p_cmds_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(cmd_continue && cmd_abort));

    p_irq_follows_event_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ev_valid && ev_irq && !soft_rst && !rst) |-> irq_out);

    p_rdata_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == '0));

endmodule

// File: tb/bridge_stat_regs_bench.sv
`timescale 1ns/1ps
module bridge_stat_regs_bench;

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        ev_valid = 1'b0, ev_irq = 1'b0, ev_dsrst = 1'b0, ev_werr = 1'b0;
    logic [31:0] ev_wdata = '0, ev_waddr = '0, ev_src = '0;
    logic        cmd_continue, cmd_abort, soft_rst, irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bridge_stat_regs #(.DW(32), .HOLD_CYCLES(HOLD)) u_bridge_stat_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ev_valid(ev_valid), .ev_irq(ev_irq), .ev_dsrst(ev_dsrst), .ev_werr(ev_werr),
        .ev_wdata(ev_wdata), .ev_waddr(ev_waddr), .ev_src(ev_src),
        .cmd_continue(cmd_continue), .cmd_abort(cmd_abort), .soft_rst(soft_rst),
        .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk(bus_rvalid === 1'b1, "R3 rvalid", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
        @(negedge clk);
        chk(bus_rvalid === 1'b0 && bus_rdata === 32'd0 && bus_ready === 1'b1,
            "R3 idle after read", bus_rdata, 32'd0);
    endtask

    task automatic do_write(input logic [1:0] a, output logic c, output logic ab, output logic s);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk(bus_ready === 1'b0, "R10 busy after write", {31'd0, bus_ready}, 32'd0);
        c = cmd_continue; ab = cmd_abort; s = soft_rst;
        @(negedge clk);
        chk(cmd_continue === 1'b0 && cmd_abort === 1'b0, "R5 pulse one cycle",
            {30'd0, cmd_continue, cmd_abort}, 32'd0);
    endtask

    task automatic do_event(input logic [2:0] b, input logic [31:0] d, input logic [31:0] ad,
                            input logic [31:0] s);
        ev_valid = 1'b1; ev_irq = b[0]; ev_dsrst = b[1]; ev_werr = b[2];
        ev_wdata = d; ev_waddr = ad; ev_src = s;
        @(negedge clk);
        ev_valid = 1'b0; ev_irq = 1'b0; ev_dsrst = 1'b0; ev_werr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic c, ab, s;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_ready === 1'b1 && bus_rvalid === 1'b0 && bus_rdata === 32'd0,
            "R1 bus idle", bus_rdata, 32'd0);
        chk(cmd_continue === 1'b0 && cmd_abort === 1'b0 && soft_rst === 1'b0 && irq_out === 1'b0,
            "R1 outputs low", {28'd0, cmd_continue, cmd_abort, soft_rst, irq_out}, 32'd0);

        // R2 R9 R6 R7: sweep all event combinations
        for (int e = 0; e < 8; e++) begin
            logic [31:0] xd, xa, xs;
            xd = 32'hD000_0000 + e; xa = 32'hA000_1000 + 32'(e * 4); xs = 32'h0000_0100 << e;
            do_event(3'(e), xd, xa, xs);
            chk(irq_out === (e != 0), "R9 irq level", {31'd0, irq_out}, {31'd0, e != 0});
            do_read(2'd0, d);
            chk(d === 32'(e), "R2 status word", d, 32'(e));
            if (e[2]) begin
                do_read(2'd1, d);
                chk(d === xd, "R6 failed data", d, xd);
                do_read(2'd2, d);
                chk(d === xa, "R6 failed address", d, xa);
            end
            if (e[0]) begin
                do_read(2'd3, d);
                chk(d === xs, "R7 irq source", d, xs);
            end
            do_write(2'd0, c, ab, s);
            chk(c === 1'b0 && ab === 1'b0, "R5 no cmd on clear", {30'd0, c, ab}, 32'd0);
            chk(irq_out === 1'b0, "R4 clear drops irq", {31'd0, irq_out}, 32'd0);
            do_read(2'd0, d);
            chk(d === 32'd0, "R4 cleared status", d, 32'd0);
        end

        // R6 captured words persist across clear; last werr e=7
        do_read(2'd1, d);
        chk(d === 32'hD000_0007, "R6 held after clear", d, 32'hD000_0007);

        // R5 command sweep
        for (int a = 0; a < 3; a++) begin
            do_write(2'(a), c, ab, s);
            chk(c === (a == 1), "R5 continue", {31'd0, c}, {31'd0, a == 1});
            chk(ab === (a == 2), "R5 abort", {31'd0, ab}, {31'd0, a == 2});
            chk(soft_rst === 1'b0, "R8 no soft reset", {31'd0, soft_rst}, 32'd0);
        end

        // R4 event during clear edge wins
        do_event(3'b100, 32'h1111_2222, 32'h3333_4444, 32'd0);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        ev_valid = 1'b1; ev_irq = 1'b1; ev_src = 32'd7;
        @(negedge clk);
        ev_valid = 1'b0; ev_irq = 1'b0;
        chk(irq_out === 1'b1, "R4 event kept irq", {31'd0, irq_out}, 32'd1);
        do_read(2'd0, d);
        chk(d === 32'd1, "R4 event beats clear", d, 32'd1);

        // R8 soft reset length, clearing, events dropped
        do_event(3'b110, 32'hCAFE_0001, 32'hBEEF_0002, 32'd0);
        do_write(2'd3, c, ab, s);
        chk(s === 1'b0 && c === 1'b0 && ab === 1'b0, "R8 no pulse during ack",
            {29'd0, s, c, ab}, 32'd0);
        n = 0;
        while (soft_rst === 1'b1 && n < 50) begin
            n++;
            ev_valid = (n == 2); ev_irq = (n == 2); ev_src = 32'h55;
            @(negedge clk);
        end
        ev_valid = 1'b0; ev_irq = 1'b0;
        chk(n == HOLD, "R8 hold length", 32'(n), 32'(HOLD));
        chk(irq_out === 1'b0, "R8 irq cleared", {31'd0, irq_out}, 32'd0);
        for (int r = 0; r < 4; r++) begin
            do_read(2'(r), d);
            chk(d === 32'd0, "R8 register cleared", d, 32'd0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule